// File: doc/BRIEF.md
# Sequential Integer Divider with Divide Error

This block divides a double-width dividend by a single-width divisor. It runs one quotient bit per clock cycle. The operand width is chosen per operation as a quarter, a half or all of the `MAX_W` parameter, which gives 8, 16 or 32 bits at the default. The quotient and the remainder both have the chosen width. A control input picks either unsigned division or two's-complement signed division. Signed division truncates toward zero, and its remainder carries the sign of the dividend.

The caller presents the operands and pulses `start` while the unit is idle. Once the operation is finished, `done` pulses for one cycle. When the divisor is zero, or the quotient cannot be held in the chosen width, `div_err` is raised in the same cycle as `done`. In that case the quotient and remainder outputs keep their previous contents. The unit reports no arithmetic status flags, because after a divide they carry no defined meaning.

Top module: `int_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, `busy`, `done` and `div_err` are 0 and `quotient` and `remainder` are 0.
- R2: `size_sel` selects the width n: 2'b00 gives n = MAX_W/4, 2'b01 gives n = MAX_W/2, and 2'b10 or 2'b11 give n = MAX_W. Only `dividend[2n-1:0]` and `divisor[n-1:0]` are used. Result bits at positions n and above are driven 0.
- R3: With `signed_op` = 0, a successful divide returns quotient = floor(dividend / divisor) and remainder = dividend − quotient·divisor, both treated as unsigned n-bit values.
- R4: With `signed_op` = 1, both operands are read as two's complement. The quotient is truncated toward zero. The remainder has the dividend's sign and a magnitude below the divisor's magnitude. Both results are given as n-bit two's complement.
- R5: A zero divisor gives `done` and `div_err` together, one clock edge after the edge that accepted `start`.
- R6: A quotient outside 0..2^n−1 (unsigned) or outside −2^(n−1)..2^(n−1)−1 (signed) raises `div_err` with `done`.
- R7: Take E0 as the edge that accepts `start`. A successful result, or a signed range error, appears with `done` at edge E0+n+2. A zero divisor, or a dividend whose upper n bits of magnitude are at least the divisor's magnitude, is reported at edge E0+1.
- R8: When `div_err` is raised, `quotient` and `remainder` keep the values of the last successful divide.
- R9: `done` is high for exactly one cycle. `busy` is high from E0 until the cycle in which `done` is seen. `start` and operand changes while busy have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a divide; accepted only while idle |
| size_sel | input | 2 | Operand width select (see R2) |
| signed_op | input | 1 | 1 = signed, 0 = unsigned |
| dividend | input | 2*MAX_W | Double-width dividend |
| divisor | input | MAX_W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide error, valid with `done` |
| quotient | output | MAX_W | Quotient, zero-extended above n |
| remainder | output | MAX_W | Remainder, zero-extended above n |

## Verification
The due cycle of each result comes from R7. Errors found up front arrive one edge after the accepting edge. Every other result, including a late signed range error, arrives n+2 edges after it. After releasing `start`, the bench counts clock edges until `done` is seen at a falling edge. It compares that count with the latency it predicted from the operands. It then reads `quotient`, `remainder` and `div_err` in that same half-cycle. It also confirms that `busy` is high one edge after acceptance and that `done` has dropped one cycle later.

// File: rtl/div_pkg.sv
// Shared definitions for the iterative divider.
// Assumes MAX_W is a multiple of 4 and at least 8.
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PREP = 2'b01,
        ST_RUN  = 2'b10,
        ST_FIN  = 2'b11
    } div_state_e;

    // Operand width selected by the size code.
    function automatic int op_width(input logic [1:0] code, input int max_w);
        case (code)
            2'b00:   return max_w / 4;
            2'b01:   return max_w / 2;
            default: return max_w;
        endcase
    endfunction

endpackage

// File: rtl/div_operand_prep.sv
// Operand preparation: masks the operands to the active width and sign-extends them when signed.
// Produces their magnitudes and flags a zero divisor or a quotient that is too large up front.
// Purely combinational. Assumes the inputs stay stable while their outputs are used.
module div_operand_prep #(
    parameter int MAX_W = 32
) (
    input  logic [$clog2(MAX_W+1)-1:0] width,
    input  logic                       signed_mode,
    input  logic [2*MAX_W-1:0]         dvd,
    input  logic [MAX_W-1:0]           dvs,
    output logic [2*MAX_W-1:0]         dvd_mag,
    output logic [MAX_W-1:0]           dvs_mag,
    output logic                       dvd_neg,
    output logic                       dvs_neg,
    output logic                       dvs_zero,
    output logic                       early_ovf
);
    localparam int DW = 2 * MAX_W;

    logic [DW-1:0]    dvd_ext;
    logic [MAX_W-1:0] dvs_ext;
    logic [DW-1:0]    upper_half;

    // Sign-extend or zero-extend both operands from the active width, then take their magnitudes.
    always_comb begin
        int n;
        n = int'(width);
        dvd_neg = signed_mode && dvd[2*n-1];
        dvs_neg = signed_mode && dvs[n-1];
        for (int i = 0; i < DW; i++) begin
            dvd_ext[i] = (i < 2*n) ? dvd[i] : dvd_neg;
        end
        for (int i = 0; i < MAX_W; i++) begin
            dvs_ext[i] = (i < n) ? dvs[i] : dvs_neg;
        end
        dvd_mag = dvd_neg ? (~dvd_ext + 1'b1) : dvd_ext;
        dvs_mag = dvs_neg ? (~dvs_ext + 1'b1) : dvs_ext;
    end

    // Up-front checks: a zero divisor, or an upper half of the magnitude that reaches the divisor.
    always_comb begin
        upper_half = dvd_mag >> width;
        dvs_zero   = (dvs_mag == '0);
        early_ovf  = (upper_half >= {{MAX_W{1'b0}}, dvs_mag});
    end

endmodule

// File: rtl/div_restore_core.sv
// Restoring division datapath that yields one quotient bit per step.
// Assumes the upper half of the loaded magnitude is below the divisor, which the caller guarantees.
// After `width` steps the quotient is in the low bits and the remainder is final.
module div_restore_core #(
    parameter int MAX_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       step,
    input  logic [$clog2(MAX_W+1)-1:0] width,
    input  logic [2*MAX_W-1:0]         dvd_mag,
    input  logic [MAX_W-1:0]           dvs_mag,
    output logic [MAX_W-1:0]           quo_mag,
    output logic [MAX_W-1:0]           rem_mag
);
    logic [MAX_W-1:0] rem_q;
    logic [MAX_W-1:0] low_q;
    logic [MAX_W-1:0] quo_q;
    logic [MAX_W-1:0] dvs_q;
    logic             valid_q;
    logic [MAX_W:0]   trial;
    logic             fits;
    logic [MAX_W:0]   trial_diff;
    logic [2*MAX_W-1:0] hi_part;

    // Shift the partial remainder left by one dividend bit and test it against the divisor.
    always_comb begin
        trial      = {rem_q, low_q[MAX_W-1]};
        fits       = (trial >= {1'b0, dvs_q});
        trial_diff = trial - {1'b0, dvs_q};
        hi_part    = dvd_mag >> width;
    end

    // Load the operands, or advance the division by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            low_q   <= '0;
            quo_q   <= '0;
            dvs_q   <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            rem_q   <= hi_part[MAX_W-1:0];
            low_q   <= dvd_mag[MAX_W-1:0] << (MAX_W - int'(width));
            quo_q   <= '0;
            dvs_q   <= dvs_mag;
            valid_q <= 1'b1;
        end else if (step) begin
            rem_q <= fits ? trial_diff[MAX_W-1:0] : trial[MAX_W-1:0];
            low_q <= {low_q[MAX_W-2:0], 1'b0};
            quo_q <= {quo_q[MAX_W-2:0], fits};
        end
    end

    assign quo_mag = quo_q;
    assign rem_mag = rem_q;

    // R3: the partial remainder stays below the divisor at every step.
    p_rem_below_divisor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (rem_q < dvs_q));

endmodule

// File: rtl/div_result_fix.sv
// Result correction: applies the signs to the quotient and remainder magnitudes and masks them to the active width.
// Flags a signed quotient outside the representable range.
// Purely combinational. Assumes the magnitudes come from a completed core run.
module div_result_fix #(
    parameter int MAX_W = 32
) (
    input  logic [$clog2(MAX_W+1)-1:0] width,
    input  logic                       signed_mode,
    input  logic                       dvd_neg,
    input  logic                       dvs_neg,
    input  logic [MAX_W-1:0]           quo_mag,
    input  logic [MAX_W-1:0]           rem_mag,
    output logic [MAX_W-1:0]           quo_out,
    output logic [MAX_W-1:0]           rem_out,
    output logic                       late_ovf
);
    logic [MAX_W-1:0] mask;
    logic [MAX_W:0]   half;
    logic             quo_neg;

    // Build the width mask and the signed magnitude limit.
    always_comb begin
        int n;
        n = int'(width);
        for (int i = 0; i < MAX_W; i++) begin
            mask[i] = (i < n);
        end
        half = (MAX_W+1)'(1) << (n - 1);
    end

    // Apply the signs, and check the signed range (a negative quotient may reach one step further).
    always_comb begin
        quo_neg  = dvd_neg ^ dvs_neg;
        late_ovf = signed_mode &&
                   (quo_neg ? ({1'b0, quo_mag} > half) : ({1'b0, quo_mag} >= half));
        quo_out  = (quo_neg ? (~quo_mag + 1'b1) : quo_mag) & mask;
        rem_out  = (dvd_neg ? (~rem_mag + 1'b1) : rem_mag) & mask;
    end

endmodule

// File: rtl/int_divider.sv
// Iterative integer divider: top level and sequencer.
// Latches the operands on an accepted start, checks the divisor, runs n restoring steps,
// then applies the signs and publishes the results together with a one-cycle done pulse.
// Assumes the caller waits for done before relying on the outputs. Reset is synchronous and active low.
module int_divider #(
    parameter int MAX_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           size_sel,
    input  logic                 signed_op,
    input  logic [2*MAX_W-1:0]   dividend,
    input  logic [MAX_W-1:0]     divisor,
    output logic                 busy,
    output logic                 done,
    output logic                 div_err,
    output logic [MAX_W-1:0]     quotient,
    output logic [MAX_W-1:0]     remainder
);
    import div_pkg::*;

    localparam int DW = 2 * MAX_W;
    localparam int CW = $clog2(MAX_W + 1);

    div_state_e       state_q;
    logic [1:0]       size_q;
    logic             signed_q;
    logic [DW-1:0]    dvd_q;
    logic [MAX_W-1:0] dvs_q;
    logic [CW-1:0]    count_q;
    logic             done_q;
    logic             err_q;
    logic [MAX_W-1:0] quo_q;
    logic [MAX_W-1:0] rem_q;

    logic [CW-1:0]    width;
    logic [DW-1:0]    dvd_mag;
    logic [MAX_W-1:0] dvs_mag;
    logic             dvd_neg;
    logic             dvs_neg;
    logic             dvs_zero;
    logic             early_ovf;
    logic             core_load;
    logic             core_step;
    logic [MAX_W-1:0] quo_mag;
    logic [MAX_W-1:0] rem_mag;
    logic [MAX_W-1:0] quo_fixed;
    logic [MAX_W-1:0] rem_fixed;
    logic             late_ovf;

    // Decode the latched size code into an operand width.
    assign width = CW'(op_width(size_q, MAX_W));

    div_operand_prep #(.MAX_W(MAX_W)) u_prep (
        .width       (width),
        .signed_mode (signed_q),
        .dvd         (dvd_q),
        .dvs         (dvs_q),
        .dvd_mag     (dvd_mag),
        .dvs_mag     (dvs_mag),
        .dvd_neg     (dvd_neg),
        .dvs_neg     (dvs_neg),
        .dvs_zero    (dvs_zero),
        .early_ovf   (early_ovf)
    );

    // Core control: load after a clean check, step while running.
    always_comb begin
        core_load = (state_q == ST_PREP) && !dvs_zero && !early_ovf;
        core_step = (state_q == ST_RUN);
    end

    div_restore_core #(.MAX_W(MAX_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (core_load),
        .step    (core_step),
        .width   (width),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag)
    );

    div_result_fix #(.MAX_W(MAX_W)) u_fix (
        .width       (width),
        .signed_mode (signed_q),
        .dvd_neg     (dvd_neg),
        .dvs_neg     (dvs_neg),
        .quo_mag     (quo_mag),
        .rem_mag     (rem_mag),
        .quo_out     (quo_fixed),
        .rem_out     (rem_fixed),
        .late_ovf    (late_ovf)
    );

    // Sequencer: accept, check, iterate, finish; results are updated only on success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            size_q   <= '0;
            signed_q <= 1'b0;
            dvd_q    <= '0;
            dvs_q    <= '0;
            count_q  <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            quo_q    <= '0;
            rem_q    <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        size_q   <= size_sel;
                        signed_q <= signed_op;
                        dvd_q    <= dividend;
                        dvs_q    <= divisor;
                        state_q  <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    if (dvs_zero || early_ovf) begin
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        count_q <= width;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    count_q <= count_q - 1'b1;
                    if (count_q == CW'(1)) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                    if (late_ovf) begin
                        err_q <= 1'b1;
                    end else begin
                        quo_q <= quo_fixed;
                        rem_q <= rem_fixed;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign div_err   = err_q;
    assign quotient  = quo_q;
    assign remainder = rem_q;

    // R9: done never lasts two cycles.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: an accepted start makes the unit busy.
    p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && start |=> busy);

    // R8: an error is only ever reported together with done.
    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> done);

    // R8: the result outputs do not move when an error is reported.
    p_hold_on_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> ($stable(quotient) && $stable(remainder)));

    // R5: a zero divisor ends the operation at the next edge with an error.
    p_zero_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PREP) && dvs_zero |=> (done && div_err));

endmodule

// File: tb/int_divider_bench.sv
`timescale 1ns/1ps
module int_divider_bench;
    localparam int MAX_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        size_sel = 2'b00;
    logic              signed_op = 1'b0;
    logic [63:0]       dividend = '0;
    logic [31:0]       divisor = '0;
    logic              busy, done, div_err;
    logic [31:0]       quotient, remainder;

    int errs = 0;
    int checks = 0;
    logic [31:0] last_q = '0;
    logic [31:0] last_r = '0;

    always #2 clk = ~clk;

    int_divider #(.MAX_W(MAX_W)) u_int_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .signed_op(signed_op), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .div_err(div_err),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference arithmetic derived from R2..R7.
    task automatic model(input logic [1:0] sz, input bit sg, input logic [63:0] dvd, input logic [31:0] dvs,
                         output bit err, output bit early, output logic [31:0] q,
                         output logic [31:0] r, output int n);
        logic [63:0] m2, mn, a, b, ma, mb, qm, rm;
        bit an, bn, neg;
        n  = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m2 = (n == 32) ? '1 : ((64'd1 << (2*n)) - 1);
        mn = (64'd1 << n) - 1;
        a  = dvd & m2;
        b  = {32'd0, dvs} & mn;
        an = sg && a[2*n-1];
        bn = sg && b[n-1];
        ma = an ? (~(a | ~m2) + 1) : a;
        mb = bn ? (~(b | ~mn) + 1) : b;
        neg = an ^ bn;
        err = 1'b0; early = 1'b0; q = '0; r = '0;
        if (mb == 0) begin
            err = 1'b1; early = 1'b1;
        end else begin
            early = ((ma >> n) >= mb);
            qm = ma / mb;
            rm = ma % mb;
            if (sg) err = neg ? (qm > (64'd1 << (n-1))) : (qm > ((64'd1 << (n-1)) - 1));
            else    err = (qm > mn);
            err = err || early;
            q = 32'((neg ? (~qm + 1) : qm) & mn);
            r = 32'((an ? (~rm + 1) : rm) & mn);
        end
    endtask

    task automatic run_op(input logic [1:0] sz, input bit sg, input logic [63:0] dvd,
                          input logic [31:0] dvs, input bit poke);
        bit e_err, e_early;
        logic [31:0] e_q, e_r;
        int n, lat, e_lat;
        model(sz, sg, dvd, dvs, e_err, e_early, e_q, e_r, n);
        e_lat = (e_err && e_early) ? 1 : n + 2;
        @(negedge clk);
        size_sel = sz; signed_op = sg; dividend = dvd; divisor = dvs; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
        if (poke) begin
            // R9: a new start with other operands while busy must not disturb the run
            start = 1'b1; dividend = ~dvd; divisor = dvs ^ 32'h5A; signed_op = ~sg;
        end
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
        end while (!done && lat < 80);
        chk(lat == e_lat, "R7 latency", 64'(lat), 64'(e_lat));
        chk(div_err === e_err, e_err ? "R5/R6 error raised" : "R6 no error", 64'(div_err), 64'(e_err));
        if (e_err) begin
            chk(quotient === last_q && remainder === last_r, "R8 hold on error",
                {quotient, remainder}, {last_q, last_r});
        end else begin
            chk(quotient === e_q, sg ? "R4 signed quotient" : "R3 unsigned quotient", 64'(quotient), 64'(e_q));
            chk(remainder === e_r, sg ? "R4 signed remainder" : "R3 unsigned remainder", 64'(remainder), 64'(e_r));
            if (n < 32) chk((quotient >> n) == 0 && (remainder >> n) == 0, "R2 upper bits zero",
                            {quotient, remainder}, 64'd0);
            last_q = e_q; last_r = e_r;
        end
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R9 done single pulse", {done, busy}, 64'd0);
    endtask

    initial begin
        #(4ns * 200000);
        errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy === 0 && done === 0 && div_err === 0 && quotient === 0 && remainder === 0,
            "R1 reset state", {busy, done, div_err, quotient[28:0], remainder}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 0 && done === 0 && div_err === 0, "R1 after reset", {busy, done, div_err}, 64'd0);

        // Directed corner cases
        run_op(2'b00, 0, 64'd100, 32'd7, 0);                // R3 basic 8-bit
        run_op(2'b00, 0, 64'h0000_0000_0000_01FE, 32'd2, 1); // R6 max unsigned quotient 255, R9 poke
        run_op(2'b00, 0, 64'h0000_0000_0000_0100, 32'd1, 0); // R6 unsigned overflow, early
        run_op(2'b00, 0, 64'd55, 32'd0, 0);                 // R5 zero divisor
        run_op(2'b00, 1, 64'h0000_0000_0000_FFF9, 32'h02, 0); // R4 -7/2 -> -3 r -1
        run_op(2'b00, 1, 64'd7, 32'h0000_00FE, 0);          // R4 7/-2 -> -3 r 1
        run_op(2'b00, 1, 64'h0000_0000_0000_FF80, 32'hFF, 0); // R6 -128/-1 late error
        run_op(2'b00, 1, 64'h0000_0000_0000_FF00, 32'h02, 0); // R6 -256/2 = -128 fits
        run_op(2'b00, 0, 64'hDEAD_BEEF_CAFE_0064, 32'hABCD_EF07, 0); // R2 ignored upper bits
        run_op(2'b01, 0, 64'h0000_0000_FFFE_0001, 32'hFFFF, 0); // R3 16-bit max
        run_op(2'b01, 1, 64'h0000_0000_8000_0000, 32'hFFFF, 0); // R6 signed 16 overflow
        run_op(2'b10, 0, 64'hFFFF_FFFE_0000_0001, 32'hFFFF_FFFF, 1); // R3 32-bit max
        run_op(2'b11, 1, 64'h8000_0000_0000_0000, 32'h0000_0001, 0); // R2 code 11 as full width, R6 error
        run_op(2'b10, 1, 64'hFFFF_FFFF_8000_0000, 32'hFFFF_FFFF, 0); // R6 -2^31/-1 late error
        run_op(2'b10, 1, 64'hFFFF_FFFF_FFFF_FFF9, 32'h0000_0002, 0); // R4 32-bit signed

        // Constrained random mix
        for (int k = 0; k < 300; k++) begin
            logic [1:0]  sz;
            bit          sg;
            logic [63:0] dvd;
            logic [31:0] dvs;
            int          n;
            sz  = 2'($urandom % 4);
            sg  = 1'($urandom % 2);
            n   = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
            dvs = $urandom;
            if ($urandom % 16 == 0) dvs = 32'd0;
            else if ($urandom % 4 == 0) dvs = dvs % 32'd16;
            dvd = {$urandom, $urandom};
            if ($urandom % 2 == 0) begin
                logic [63:0] lowv;
                lowv = dvd & ((64'd1 << n) - 1);
                if (sg && lowv[n-1]) lowv = lowv | ~((64'd1 << n) - 1);
                dvd = lowv;
            end
            run_op(sz, sg, dvd, dvs, (k % 5) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule